// File: doc/BRIEF.md
# Multi-Line Interrupt Controller with Countdown Timer

This block gathers interrupt requests for a small processor core. It watches a vector of request lines, by default 32 of them. Three events inside the chip share the lowest lines: the countdown timer uses line 0, an illegal-instruction or break event uses line 1, and a misaligned-access bus error uses line 2. Each line is either edge-captured or level-following, which a parameter sets. A second parameter can disable a line for good. The block holds a pending vector, a software mask that starts fully masked, and a one-shot down-counter.

The processor talks to the block with single-cycle strobes:
- A mask write installs a new mask. The old mask can be read on the same cycle.
- A timer load works the same way for the count.
- A wait request is answered once anything is pending.

When an unmasked line is pending and no handler is running, the block raises a take request and shows a fixed handler address. When the processor accepts, all pending unmasked lines are serviced in one handler call. Their end-of-interrupt outputs stay high until the processor signals return. A line-1 or line-2 event that arrives while that line is masked raises a sticky halt output.

Top module: `irqc_top`

## Requirements
- R1: After reset the mask reads all ones. Pending, end-of-interrupt, halt, take request and timer count all read zero.
- R2: On a cycle with `mask_wr` high, `mask_rd` shows the previous mask. From the next cycle it shows `mask_wdata`.
- R3: A line whose bit is set in `HARD_MASK` never shows as pending, whatever drives it.
- R4: A line whose `LATCH_MASK` bit is 1 becomes pending one cycle after a single-cycle pulse. It stays pending until a handler entry services it.
- R5: A line whose `LATCH_MASK` bit is 0 shows the input level on `pend_o` one cycle later, and drops when the input drops.
- R6: `irq_take` is high exactly when no handler is active and `pend_o & ~mask_rd` is non-zero. `svc_mask` equals `pend_o & ~mask_rd`. `irq_vec` equals `HANDLER_VEC`, which defaults to 0x00000010.
- R7: `irq_enter` while `irq_take` is high has these effects from the next cycle: `eoi` equals the serviced set, the serviced latched lines are cleared, and `irq_take` stays low while the handler is active. New events keep collecting in `pend_o` during the handler.
- R8: `irq_ret` clears `eoi` on the next cycle. This allows a new take request.
- R9: A timer load of V shows the previous count on `tmr_rd` in the load cycle and V after it. The count then falls by one per cycle. Bit 0 of `pend_o` rises in the same cycle the count reaches 0. A load of 0 stops the timer, and it raises nothing.
- R10: `wait_ready` is high exactly when `wait_req` is high and `pend_o` is non-zero. `pend_o` carries the pending bitmask.
- R11: `ev_illegal` sets pending bit 1 and `ev_buserr` sets pending bit 2. If the matching mask bit is 1 when either event arrives, `halt` rises on the next cycle and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_IRQ | External request lines |
| ev_illegal | input | 1 | Internal illegal-instruction/break event (line 1) |
| ev_buserr | input | 1 | Internal misaligned-access event (line 2) |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | N_IRQ | New mask value |
| mask_rd | output | N_IRQ | Current mask (old value during a write) |
| tmr_ld | input | 1 | Timer load strobe |
| tmr_wdata | input | TMR_W | Timer load value |
| tmr_rd | output | TMR_W | Current count (old value during a load) |
| wait_req | input | 1 | Processor is waiting for an interrupt |
| wait_ready | output | 1 | Wait may complete |
| pend_o | output | N_IRQ | Pending bitmask |
| irq_take | output | 1 | Request to enter the handler |
| irq_vec | output | 32 | Handler start address |
| svc_mask | output | N_IRQ | Lines an entry would service |
| irq_enter | input | 1 | Processor enters the handler |
| irq_ret | input | 1 | Processor returns from the handler |
| eoi | output | N_IRQ | Per-line end-of-interrupt |
| halt | output | 1 | Sticky fault halt |

## Verification
On every cycle the assertions check the following:
- Disabled lines stay clear.
- `eoi` holds its value unless there is an entry or a return, and a return empties it.
- No take request is raised while `eoi` is non-zero.
- The counter steps down by exactly one.
- The halt flag stays set.

Other behaviour needs the bench's scenarios, because it depends on exact cycle timing:
- the old mask or count is returned during a write or load;
- a pulse on a latched line is captured;
- a level line follows its input;
- pending bit 0 rises at the moment the count reaches zero;
- a masked fault raises the halt.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int LINE_TIMER = 0;
    localparam int LINE_ILL   = 1;
    localparam int LINE_BUS   = 2;

    typedef struct packed {
        logic fire;
        logic ill;
        logic bus;
    } int_src_t;

    function automatic logic next_pend(input logic hard, input logic latched,
                                       input logic cur, input logic clr,
                                       input logic src);
        if (hard)
            return 1'b0;
        else if (latched)
            return (cur & ~clr) | src;
        else
            return src;
    endfunction
endpackage

// File: rtl/irqc_timer.sv
module irqc_timer #(
    parameter int TMR_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic [TMR_W-1:0] wdata,
    output logic [TMR_W-1:0] count,
    output logic             fire
);
    localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

    assign fire = !ld && (count == ONE);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (ld)
            count <= wdata;
        else if (count != '0)
            count <= count - ONE;
    end
endmodule

// File: rtl/irqc_line.sv
module irqc_line
    import irqc_pkg::*;
#(
    parameter logic HARD    = 1'b0,
    parameter logic LATCHED = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic src,
    input  logic clr,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b0;
        else
            pend <= next_pend(HARD, LATCHED, pend, clr, src);
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int                N_IRQ       = 32,
    parameter int                TMR_W       = 32,
    parameter logic [N_IRQ-1:0]  HARD_MASK   = '0,
    parameter logic [N_IRQ-1:0]  LATCH_MASK  = '1,
    parameter logic [31:0]       HANDLER_VEC = 32'h0000_0010
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IRQ-1:0] irq_in,
    input  logic             ev_illegal,
    input  logic             ev_buserr,
    input  logic             mask_wr,
    input  logic [N_IRQ-1:0] mask_wdata,
    output logic [N_IRQ-1:0] mask_rd,
    input  logic             tmr_ld,
    input  logic [TMR_W-1:0] tmr_wdata,
    output logic [TMR_W-1:0] tmr_rd,
    input  logic             wait_req,
    output logic             wait_ready,
    output logic [N_IRQ-1:0] pend_o,
    output logic             irq_take,
    output logic [31:0]      irq_vec,
    output logic [N_IRQ-1:0] svc_mask,
    input  logic             irq_enter,
    input  logic             irq_ret,
    output logic [N_IRQ-1:0] eoi,
    output logic             halt
);
    logic [N_IRQ-1:0] mask_q, eoi_q, src, clr, pend;
    logic             halt_q, enter_ok, in_handler;
    int_src_t         isrc;

    irqc_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk(clk), .rst(rst), .ld(tmr_ld), .wdata(tmr_wdata),
        .count(tmr_rd), .fire(isrc.fire)
    );

    assign isrc.ill = ev_illegal;
    assign isrc.bus = ev_buserr;

    always_comb begin
        src = irq_in;
        src[LINE_TIMER] = irq_in[LINE_TIMER] | isrc.fire;
        src[LINE_ILL]   = irq_in[LINE_ILL]   | isrc.ill;
        src[LINE_BUS]   = irq_in[LINE_BUS]   | isrc.bus;
    end

    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        irqc_line #(.HARD(HARD_MASK[i]), .LATCHED(LATCH_MASK[i])) u_line (
            .clk(clk), .rst(rst), .src(src[i]), .clr(clr[i]), .pend(pend[i])
        );
    end

    assign in_handler = |eoi_q;
    assign svc_mask   = pend & ~mask_q;
    assign irq_take   = !in_handler && (|svc_mask);
    assign enter_ok   = irq_enter && irq_take;
    assign clr        = enter_ok ? svc_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            eoi_q  <= '0;
            halt_q <= 1'b0;
        end else begin
            if (mask_wr)
                mask_q <= mask_wdata;
            if (enter_ok)
                eoi_q <= svc_mask;
            else if (irq_ret)
                eoi_q <= '0;
            if ((ev_illegal && mask_q[LINE_ILL]) || (ev_buserr && mask_q[LINE_BUS]))
                halt_q <= 1'b1;
        end
    end

    assign mask_rd    = mask_q;
    assign pend_o     = pend;
    assign eoi        = eoi_q;
    assign halt       = halt_q;
    assign irq_vec    = HANDLER_VEC;
    assign wait_ready = wait_req && (|pend);
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int               N_IRQ     = 32,
    parameter int               TMR_W     = 32,
    parameter logic [N_IRQ-1:0] HARD_MASK = '0
) (
    input logic             clk,
    input logic             rst,
    input logic [N_IRQ-1:0] pend_o,
    input logic [N_IRQ-1:0] eoi,
    input logic             irq_take,
    input logic             irq_enter,
    input logic             irq_ret,
    input logic             tmr_ld,
    input logic [TMR_W-1:0] tmr_rd,
    input logic             halt
);
    a_r3_hard_never_pending: assert property (@(posedge clk) disable iff (rst)
        (pend_o & HARD_MASK) == '0);

    a_r7_eoi_held: assert property (@(posedge clk) disable iff (rst)
        (!irq_ret && !(irq_enter && irq_take)) |=> $stable(eoi));

    a_r7_no_take_in_handler: assert property (@(posedge clk) disable iff (rst)
        (eoi != '0) |-> !irq_take);

    a_r8_ret_clears: assert property (@(posedge clk) disable iff (rst)
        (irq_ret && !irq_take) |=> (eoi == '0));

    a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
        (!tmr_ld && tmr_rd != '0) |=> (tmr_rd == $past(tmr_rd) - TMR_W'(1)));

    a_r11_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halt |=> halt);
endmodule

bind irqc_top irqc_chk #(.N_IRQ(N_IRQ), .TMR_W(TMR_W), .HARD_MASK(HARD_MASK)) u_chk (
    .clk(clk), .rst(rst), .pend_o(pend_o), .eoi(eoi), .irq_take(irq_take),
    .irq_enter(irq_enter), .irq_ret(irq_ret), .tmr_ld(tmr_ld), .tmr_rd(tmr_rd),
    .halt(halt)
);

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
    localparam logic [31:0] HARD  = 32'h8000_0000;
    localparam logic [31:0] LATCH = 32'hBFFF_FFFF;

    logic        clk = 0, rst = 1;
    logic [31:0] irq_in = '0, mask_wdata = '0, mask_rd, pend_o, svc_mask, eoi, irq_vec;
    logic [31:0] tmr_wdata = '0, tmr_rd;
    logic        ev_illegal = 0, ev_buserr = 0, mask_wr = 0, tmr_ld = 0;
    logic        wait_req = 0, wait_ready, irq_take, irq_enter = 0, irq_ret = 0, halt;
    int          total = 0, bad = 0;
    logic        done = 0;

    always #2.5 clk = ~clk;

    irqc_top #(.HARD_MASK(HARD), .LATCH_MASK(LATCH)) u_dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .ev_illegal(ev_illegal),
        .ev_buserr(ev_buserr), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .mask_rd(mask_rd), .tmr_ld(tmr_ld), .tmr_wdata(tmr_wdata), .tmr_rd(tmr_rd),
        .wait_req(wait_req), .wait_ready(wait_ready), .pend_o(pend_o),
        .irq_take(irq_take), .irq_vec(irq_vec), .svc_mask(svc_mask),
        .irq_enter(irq_enter), .irq_ret(irq_ret), .eoi(eoi), .halt(halt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic idle();
        irq_in = '0; ev_illegal = 0; ev_buserr = 0; mask_wr = 0; tmr_ld = 0;
        irq_enter = 0; irq_ret = 0;
    endtask

    task automatic service();
        irq_enter = 1; step(); irq_enter = 0;
        irq_ret = 1; step(); irq_ret = 0;
    endtask

    function automatic logic [31:0] exp_svc(input logic [31:0] p, input logic [31:0] m);
        return p & ~m;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_pend, exp_mask;
        void'($urandom(32'd4242));
        step(); step(); rst = 0; #1;
        // R1 reset state
        chk("R1 mask", mask_rd, 32'hFFFF_FFFF);
        chk("R1 pend", pend_o, 0);
        chk("R1 eoi", eoi, 0);
        chk("R1 halt", {31'd0, halt}, 0);
        chk("R1 take", {31'd0, irq_take}, 0);
        chk("R1 tmr", tmr_rd, 0);
        chk("R6 vec", irq_vec, 32'h10);
        wait_req = 1; #1;
        chk("R10 no pend", {31'd0, wait_ready}, 0);
        // R2 mask write
        mask_wr = 1; mask_wdata = 0; #1;
        chk("R2 old mask", mask_rd, 32'hFFFF_FFFF);
        step(); idle();
        chk("R2 new mask", mask_rd, 0);
        // R3/R4 latched pulse and hard-masked line
        irq_in = 32'h8000_0020; step(); idle();
        chk("R3 R4 pend", pend_o, 32'h20);
        step(); step(); step();
        chk("R4 held", pend_o, 32'h20);
        chk("R6 take", {31'd0, irq_take}, 1);
        chk("R6 svc", svc_mask, exp_svc(32'h20, 0));
        chk("R10 ready", {31'd0, wait_ready}, 1);
        chk("R10 pend", pend_o, 32'h20);
        wait_req = 0;
        // R7 entry
        irq_enter = 1; step(); idle();
        chk("R7 eoi", eoi, 32'h20);
        chk("R7 cleared", pend_o, 0);
        irq_in = 32'h80; step(); idle();
        chk("R7 accumulate", pend_o, 32'h80);
        chk("R7 no take", {31'd0, irq_take}, 0);
        step();
        chk("R7 eoi hold", eoi, 32'h20);
        // R8 return
        irq_ret = 1; step(); idle();
        chk("R8 eoi clr", eoi, 0);
        chk("R8 take", {31'd0, irq_take}, 1);
        chk("R8 svc", svc_mask, 32'h80);
        service();
        chk("R7 after service", pend_o, 0);
        // R5 level line 30
        irq_in = 32'h4000_0000; step();
        chk("R5 high", pend_o, 32'h4000_0000);
        irq_in = 0; step();
        chk("R5 low", pend_o, 0);
        // R9 timer
        tmr_ld = 1; tmr_wdata = 5; #1;
        chk("R9 old cnt", tmr_rd, 0);
        step(); idle();
        chk("R9 loaded", tmr_rd, 5);
        repeat (4) step();
        chk("R9 cnt1", tmr_rd, 1);
        chk("R9 not yet", pend_o, 0);
        step();
        chk("R9 zero", tmr_rd, 0);
        chk("R9 fire", pend_o, 32'h1);
        step(); step();
        chk("R9 stays 0", tmr_rd, 0);
        service();
        tmr_ld = 1; tmr_wdata = 3; step(); idle(); step();
        tmr_ld = 1; tmr_wdata = 0; #1;
        chk("R9 old on reload", tmr_rd, 2);
        step(); idle();
        repeat (6) step();
        chk("R9 disabled", pend_o, 0);
        chk("R9 disabled cnt", tmr_rd, 0);
        // random latched pulses and mask writes (R2 R4 R3)
        exp_pend = 0; exp_mask = 0;
        for (int k = 0; k < 300; k++) begin
            logic [31:0] p;
            p = $urandom & 32'hBFFF_FFF8;
            irq_in = p;
            mask_wr = $urandom_range(0, 3) == 0;
            mask_wdata = $urandom;
            #1;
            chk("R2 rand mask", mask_rd, exp_mask);
            chk("R6 rand svc", svc_mask, exp_svc(exp_pend, exp_mask));
            if (mask_wr) exp_mask = mask_wdata;
            exp_pend = (exp_pend | p) & ~HARD;
            step();
            chk("R4 rand pend", pend_o, exp_pend);
        end
        idle();
        mask_wr = 1; mask_wdata = 0; step(); idle();
        service();
        chk("R7 rand clear", pend_o, 0);
        // R11 internal events
        ev_illegal = 1; step(); idle();
        chk("R11 ill pend", pend_o, 32'h2);
        chk("R11 no halt", {31'd0, halt}, 0);
        mask_wr = 1; mask_wdata = 32'hFFFF_FFFF; step(); idle();
        ev_buserr = 1; step(); idle();
        chk("R11 bus pend", pend_o, 32'h6);
        chk("R11 halt", {31'd0, halt}, 1);
        step(); step();
        chk("R11 halt sticky", {31'd0, halt}, 1);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule